// File: doc/BRIEF.md
# Exception Priority and Double-Fault Resolver

At every instruction boundary this block looks at the fault, trap and interrupt condition flags gathered by the fetch, decode, coprocessor-check and memory-reference stages. It picks exactly one exception vector using a fixed check order. The vector appears on the output with a one-cycle valid pulse. The flags are sampled on the clock edge where the boundary strobe is high.

The block also tracks nested delivery. Once a vector has been raised, the block records which kind of handler entry is pending. A fault seen before the handler-entered strobe is treated as a fault during entry. Depending on the class of entry, that fault becomes a double fault (vector 8), a second page fault (vector 14), or a move to a sticky shutdown state that only reset leaves.

Top module: `excPrioResolver`

## Requirements
- R1: After reset the valid strobe and the shutdown flag are 0, and no handler entry is pending.
- R2: Boundary priority, highest first: debug trap on the completed instruction (vector 1), execution breakpoint on the next instruction (vector 1), external requests, fetch segmentation fault (vector 13 when `fetchSegGp`=1, else 11), fetch page fault (vector 14), decode faults, coprocessor checks, memory references.
- R3: Decode faults are checked in this order: illegal opcode gives 6; a protected-only opcode gives 6, but only when `realOrV86`=1; an over-long instruction gives 13; a privilege violation gives 13.
- R4: A WAIT opcode gives vector 7 only when TS and MP are both 1. A coprocessor ESCAPE opcode gives vector 7 when EM or TS is 1.
- R5: A WAIT or ESCAPE opcode with the coprocessor error input high gives vector 16, but only if no vector 7 condition holds.
- R6: Memory references are checked in index order starting at 0. Within one reference the segmentation fault comes before the page fault. The segmentation code maps as 00→11, 01→12, 1x→13.
- R7: Each boundary strobe with at least one active condition produces exactly one valid pulse in the next cycle, carrying one vector. With no active condition it produces none.
- R8: NMI (vector 2) beats INTR. INTR (vector `intrVec`) counts only when `intrEn`=1. Neither request counts while a handler entry is pending.
- R9: A fault other than a page fault during entry to a vector 10–13 handler raises vector 8. A page fault during that entry raises vector 14.
- R10: A fault other than a page fault during entry to the vector 14 handler raises vector 8. A page fault during that entry re-raises vector 14.
- R11: Any fault during the re-raised vector 14 entry, or during the vector 8 entry, sets shutdown with no valid pulse. Shutdown stays set until reset, and no further vector is raised.
- R12: `handlerEntered` ends the pending entry, so the next fault is resolved as a fresh boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| checkStb | input | 1 | Instruction boundary: evaluate the flags |
| handlerEntered | input | 1 | Pending handler entry completed |
| dbgTrap | input | 1 | Debug trap from the completed instruction |
| bkptFault | input | 1 | Execution breakpoint on the next instruction |
| nmiReq | input | 1 | Non-maskable interrupt request |
| intrReq | input | 1 | Maskable interrupt request |
| intrEn | input | 1 | Maskable interrupt enable |
| intrVec | input | 8 | Vector of the maskable interrupt |
| fetchSegFault | input | 1 | Segmentation fault on fetch |
| fetchSegGp | input | 1 | Fetch segmentation fault is general (13) rather than not-present (11) |
| fetchPageFault | input | 1 | Page fault on fetch |
| decIllegal | input | 1 | Illegal opcode |
| decProtOnly | input | 1 | Protected-only instruction |
| realOrV86 | input | 1 | Real or virtual-8086 mode |
| decTooLong | input | 1 | Instruction longer than 15 bytes |
| decPrivViol | input | 1 | Privilege violation |
| opWait | input | 1 | WAIT opcode |
| opEsc | input | 1 | Coprocessor ESCAPE opcode |
| crTs | input | 1 | Task-switched control bit |
| crMp | input | 1 | Monitor-coprocessor control bit |
| crEm | input | 1 | Emulate-coprocessor control bit |
| cpErr | input | 1 | Coprocessor error input |
| memSegFault | input | MEM_REFS | Segmentation fault per memory reference |
| memSegCode | input | 2*MEM_REFS | Segmentation fault code per reference |
| memPageFault | input | MEM_REFS | Page fault per memory reference |
| excValid | output | 1 | One-cycle pulse: a vector is raised |
| excVector | output | 8 | Raised vector number |
| shutdown | output | 1 | Shutdown, sticky until reset |

## Verification
A wrong nesting state always shows up at the very next boundary that carries a fault. A missing or extra double fault appears as the wrong vector. A premature shutdown appears as a lost valid pulse with `shutdown` high. Masked or unmasked interrupts show up as an unexpected or missing pulse one cycle after the boundary strobe.

Priority errors show as the wrong `excVector` in the cycle right after `checkStb`. Random flag mixes, interleaved with handler completions, compare every boundary against a reference model kept in the bench.

// File: rtl/excPkg.sv
package excPkg;
  localparam int VEC_W = 8;

  localparam logic [VEC_W-1:0] VEC_DEBUG = 8'd1;
  localparam logic [VEC_W-1:0] VEC_NMI   = 8'd2;
  localparam logic [VEC_W-1:0] VEC_INVOP = 8'd6;
  localparam logic [VEC_W-1:0] VEC_NODEV = 8'd7;
  localparam logic [VEC_W-1:0] VEC_DF    = 8'd8;
  localparam logic [VEC_W-1:0] VEC_TSS   = 8'd10;
  localparam logic [VEC_W-1:0] VEC_NP    = 8'd11;
  localparam logic [VEC_W-1:0] VEC_SS    = 8'd12;
  localparam logic [VEC_W-1:0] VEC_GP    = 8'd13;
  localparam logic [VEC_W-1:0] VEC_PF    = 8'd14;
  localparam logic [VEC_W-1:0] VEC_MF    = 8'd16;

  // Strobes from the nesting control to the priority datapath.
  typedef struct packed {
    logic raiseCand;
    logic raiseDf;
    logic maskExt;
  } excStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BENIGN,
    ST_SEG,
    ST_PF,
    ST_PF2,
    ST_DF,
    ST_SHUT
  } nestStateT;

  function automatic logic [VEC_W-1:0] segCodeVec(input logic [1:0] code);
    case (code)
      2'b00:   return VEC_NP;
      2'b01:   return VEC_SS;
      default: return VEC_GP;
    endcase
  endfunction
endpackage

// File: rtl/excPrioDatapath.sv
module excPrioDatapath
  import excPkg::*;
#(
  parameter int MEM_REFS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  excStrobeT             stb,
  input  logic                  dbgTrap,
  input  logic                  bkptFault,
  input  logic                  nmiReq,
  input  logic                  intrReq,
  input  logic                  intrEn,
  input  logic [VEC_W-1:0]      intrVec,
  input  logic                  fetchSegFault,
  input  logic                  fetchSegGp,
  input  logic                  fetchPageFault,
  input  logic                  decIllegal,
  input  logic                  decProtOnly,
  input  logic                  realOrV86,
  input  logic                  decTooLong,
  input  logic                  decPrivViol,
  input  logic                  opWait,
  input  logic                  opEsc,
  input  logic                  crTs,
  input  logic                  crMp,
  input  logic                  crEm,
  input  logic                  cpErr,
  input  logic [MEM_REFS-1:0]   memSegFault,
  input  logic [2*MEM_REFS-1:0] memSegCode,
  input  logic [MEM_REFS-1:0]   memPageFault,
  output logic                  candHit,
  output logic [VEC_W-1:0]      candVec,
  output logic                  excValid,
  output logic [VEC_W-1:0]      excVector
);
  localparam int REF_IDX_W = (MEM_REFS > 1) ? $clog2(MEM_REFS) : 1;

  logic [VEC_W-1:0] refVec [MEM_REFS];
  logic [MEM_REFS-1:0] refHit;

  // Per-reference resolution: segmentation wins over paging inside one reference.
  for (genvar g = 0; g < MEM_REFS; g++) begin : g_ref
    assign refHit[g] = memSegFault[g] | memPageFault[g];
    assign refVec[g] = memSegFault[g] ? segCodeVec(memSegCode[2*g +: 2]) : VEC_PF;
  end

  logic memHit;
  logic [VEC_W-1:0] memVec;
  logic [REF_IDX_W-1:0] memIdx;

  // Lowest index reference is checked first.
  always_comb begin
    memHit = 1'b0;
    memIdx = '0;
    for (int i = MEM_REFS - 1; i >= 0; i--) begin
      if (refHit[i]) begin
        memHit = 1'b1;
        memIdx = REF_IDX_W'(i);
      end
    end
    memVec = refVec[memIdx];
  end

  logic extOk;
  assign extOk = !stb.maskExt;

  always_comb begin
    candHit = 1'b1;
    candVec = '0;
    if (dbgTrap)                             candVec = VEC_DEBUG;
    else if (bkptFault)                      candVec = VEC_DEBUG;
    else if (nmiReq && extOk)                candVec = VEC_NMI;
    else if (intrReq && intrEn && extOk)     candVec = intrVec;
    else if (fetchSegFault)                  candVec = fetchSegGp ? VEC_GP : VEC_NP;
    else if (fetchPageFault)                 candVec = VEC_PF;
    else if (decIllegal)                     candVec = VEC_INVOP;
    else if (decProtOnly && realOrV86)       candVec = VEC_INVOP;
    else if (decTooLong)                     candVec = VEC_GP;
    else if (decPrivViol)                    candVec = VEC_GP;
    else if (opWait && crTs && crMp)         candVec = VEC_NODEV;
    else if (opEsc && (crEm || crTs))        candVec = VEC_NODEV;
    else if ((opWait || opEsc) && cpErr)     candVec = VEC_MF;
    else if (memHit)                         candVec = memVec;
    else                                     candHit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excValid  <= 1'b0;
      excVector <= '0;
    end else begin
      excValid <= stb.raiseCand | stb.raiseDf;
      if (stb.raiseDf)        excVector <= VEC_DF;
      else if (stb.raiseCand) excVector <= candVec;
    end
  end

  // R9 and R10: a double-fault decision reaches the ports one cycle later.
  p_df_vector_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.raiseDf |=> (excValid && excVector == VEC_DF));

  // R7: at most one raise decision per boundary.
  p_single_raise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.raiseCand, stb.raiseDf}));

  // R8: masked external requests never produce vector 2 on their own.
  p_nmi_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.maskExt && candHit && candVec == VEC_NMI) |-> (dbgTrap || bkptFault || memHit ||
      fetchSegFault || fetchPageFault || decIllegal || decTooLong || decPrivViol ||
      decProtOnly || opWait || opEsc || (intrReq && intrEn)));
endmodule

// File: rtl/excNestCtrl.sv
module excNestCtrl
  import excPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             checkStb,
  input  logic             handlerEntered,
  input  logic             candHit,
  input  logic [VEC_W-1:0] candVec,
  output excStrobeT        stb,
  output logic             shutdown
);
  nestStateT state, nextState;

  logic candIsPf, candIsSeg;
  assign candIsPf  = (candVec == VEC_PF);
  assign candIsSeg = (candVec >= VEC_TSS) && (candVec <= VEC_GP);

  always_comb begin
    stb         = '0;
    stb.maskExt = (state != ST_IDLE);
    nextState   = state;
    if (checkStb && candHit) begin
      case (state)
        ST_IDLE, ST_BENIGN: begin
          stb.raiseCand = 1'b1;
          nextState = candIsPf ? ST_PF : (candIsSeg ? ST_SEG : ST_BENIGN);
        end
        ST_SEG, ST_PF: begin
          if (candIsPf) begin
            stb.raiseCand = 1'b1;
            nextState = (state == ST_PF) ? ST_PF2 : ST_PF;
          end else begin
            stb.raiseDf = 1'b1;
            nextState = ST_DF;
          end
        end
        ST_PF2, ST_DF: nextState = ST_SHUT;
        default: nextState = ST_SHUT;
      endcase
    end else if (handlerEntered && state != ST_SHUT) begin
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign shutdown = (state == ST_SHUT);

  // R11: shutdown is held until reset.
  p_shut_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    shutdown |=> shutdown);

  // R9 and R10: double faults come only from a pending segment or page-fault entry.
  p_df_nested_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.raiseDf |-> $past(stb.raiseCand) || (state == ST_SEG || state == ST_PF));

  // R12: a completed entry with no new boundary leaves the block idle.
  p_entry_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    (handlerEntered && !checkStb && !shutdown) |=> !stb.maskExt);
endmodule

// File: rtl/excPrioResolver.sv
module excPrioResolver
  import excPkg::*;
#(
  parameter int MEM_REFS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  checkStb,
  input  logic                  handlerEntered,
  input  logic                  dbgTrap,
  input  logic                  bkptFault,
  input  logic                  nmiReq,
  input  logic                  intrReq,
  input  logic                  intrEn,
  input  logic [7:0]            intrVec,
  input  logic                  fetchSegFault,
  input  logic                  fetchSegGp,
  input  logic                  fetchPageFault,
  input  logic                  decIllegal,
  input  logic                  decProtOnly,
  input  logic                  realOrV86,
  input  logic                  decTooLong,
  input  logic                  decPrivViol,
  input  logic                  opWait,
  input  logic                  opEsc,
  input  logic                  crTs,
  input  logic                  crMp,
  input  logic                  crEm,
  input  logic                  cpErr,
  input  logic [MEM_REFS-1:0]   memSegFault,
  input  logic [2*MEM_REFS-1:0] memSegCode,
  input  logic [MEM_REFS-1:0]   memPageFault,
  output logic                  excValid,
  output logic [7:0]            excVector,
  output logic                  shutdown
);
  excStrobeT stb;
  logic candHit;
  logic [VEC_W-1:0] candVec;

  excNestCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .checkStb(checkStb), .handlerEntered(handlerEntered),
    .candHit(candHit), .candVec(candVec), .stb(stb), .shutdown(shutdown)
  );

  excPrioDatapath #(.MEM_REFS(MEM_REFS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .dbgTrap(dbgTrap), .bkptFault(bkptFault), .nmiReq(nmiReq), .intrReq(intrReq),
    .intrEn(intrEn), .intrVec(intrVec), .fetchSegFault(fetchSegFault),
    .fetchSegGp(fetchSegGp), .fetchPageFault(fetchPageFault), .decIllegal(decIllegal),
    .decProtOnly(decProtOnly), .realOrV86(realOrV86), .decTooLong(decTooLong),
    .decPrivViol(decPrivViol), .opWait(opWait), .opEsc(opEsc), .crTs(crTs),
    .crMp(crMp), .crEm(crEm), .cpErr(cpErr), .memSegFault(memSegFault),
    .memSegCode(memSegCode), .memPageFault(memPageFault),
    .candHit(candHit), .candVec(candVec), .excValid(excValid), .excVector(excVector)
  );

  // R11: no vector leaves the block once it is shut down.
  p_quiet_shutdown_r11: assert property (@(posedge clk) disable iff (!rstN)
    shutdown |-> !excValid);

  // R7: a valid pulse always follows a boundary strobe.
  p_valid_after_check_r7: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> $past(checkStb));
endmodule

// File: tb/excPrioResolver_tb.sv
`timescale 1ns/1ps
module excPrioResolver_tb;
  localparam int MEM_REFS = 2;
  localparam realtime CLK_P = 20.0;

  logic clk = 1'b0;
  logic rstN, checkStb, handlerEntered;
  logic dbgTrap, bkptFault, nmiReq, intrReq, intrEn;
  logic [7:0] intrVec;
  logic fetchSegFault, fetchSegGp, fetchPageFault;
  logic decIllegal, decProtOnly, realOrV86, decTooLong, decPrivViol;
  logic opWait, opEsc, crTs, crMp, crEm, cpErr;
  logic [MEM_REFS-1:0] memSegFault, memPageFault;
  logic [2*MEM_REFS-1:0] memSegCode;
  logic excValid, shutdown;
  logic [7:0] excVector;

  int nChecks = 0, nFails = 0;
  int mState = 0; // 0 idle,1 benign,2 seg entry,3 pf entry,4 pf re-entry,5 df entry,6 shutdown
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  excPrioResolver #(.MEM_REFS(MEM_REFS)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clearIn();
    checkStb = 0; handlerEntered = 0; dbgTrap = 0; bkptFault = 0; nmiReq = 0;
    intrReq = 0; intrEn = 0; intrVec = 8'd32; fetchSegFault = 0; fetchSegGp = 0;
    fetchPageFault = 0; decIllegal = 0; decProtOnly = 0; realOrV86 = 0;
    decTooLong = 0; decPrivViol = 0; opWait = 0; opEsc = 0; crTs = 0; crMp = 0;
    crEm = 0; cpErr = 0; memSegFault = 0; memPageFault = 0; memSegCode = 0;
  endtask

  // Reference priority built from R2..R6 and R8.
  function automatic logic [8:0] refCand(input bit masked);
    for (int i = 0; i < MEM_REFS; i++) begin : refScan
    end
    if (dbgTrap || bkptFault) return {1'b1, 8'd1};
    if (nmiReq && !masked) return {1'b1, 8'd2};
    if (intrReq && intrEn && !masked) return {1'b1, intrVec};
    if (fetchSegFault) return {1'b1, fetchSegGp ? 8'd13 : 8'd11};
    if (fetchPageFault) return {1'b1, 8'd14};
    if (decIllegal) return {1'b1, 8'd6};
    if (decProtOnly && realOrV86) return {1'b1, 8'd6};
    if (decTooLong || decPrivViol) return {1'b1, 8'd13};
    if (opWait && crTs && crMp) return {1'b1, 8'd7};
    if (opEsc && (crEm || crTs)) return {1'b1, 8'd7};
    if ((opWait || opEsc) && cpErr) return {1'b1, 8'd16};
    for (int i = 0; i < MEM_REFS; i++) begin
      if (memSegFault[i]) begin
        case (memSegCode[2*i +: 2])
          2'b00: return {1'b1, 8'd11};
          2'b01: return {1'b1, 8'd12};
          default: return {1'b1, 8'd13};
        endcase
      end
      if (memPageFault[i]) return {1'b1, 8'd14};
    end
    return 9'd0;
  endfunction

  function automatic int classOf(input logic [7:0] v);
    if (v == 8'd14) return 3;
    if (v >= 8'd10 && v <= 8'd13) return 2;
    return 1;
  endfunction

  // Called at a negedge with flags already driven.
  task automatic boundary(input string req);
    logic [8:0] c;
    bit expValid;
    logic [7:0] expVec;
    int nxt;
    c = refCand(mState != 0);
    expValid = 0; expVec = 0; nxt = mState;
    if (c[8]) begin
      case (mState)
        0, 1: begin expValid = 1; expVec = c[7:0]; nxt = classOf(c[7:0]); end
        2, 3: begin
          if (c[7:0] == 8'd14) begin expValid = 1; expVec = 8'd14; nxt = (mState == 3) ? 4 : 3; end
          else begin expValid = 1; expVec = 8'd8; nxt = 5; end
        end
        default: nxt = 6;
      endcase
    end
    checkStb = 1;
    @(posedge clk); #1;
    chk(excValid == expValid, req, excValid, expValid);
    if (expValid) chk(excVector == expVec, req, excVector, expVec);
    chk(shutdown == (nxt == 6), req, shutdown, nxt == 6);
    mState = nxt;
    clearIn();
  endtask

  task automatic entered();
    @(negedge clk);
    handlerEntered = 1;
    @(posedge clk); #1;
    handlerEntered = 0;
    if (mState != 6) mState = 0;
    chk(excValid == 0, "R12", excValid, 0);
  endtask

  task automatic doReset();
    clearIn();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    mState = 0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    void'($urandom(32'h1C3A5EED));
    doReset();
    @(posedge clk); #1;
    chk(excValid == 0, "R1", excValid, 0);
    chk(shutdown == 0, "R1", shutdown, 0);

    // R2: debug trap beats everything below it
    @(negedge clk); dbgTrap = 1; nmiReq = 1; decIllegal = 1; boundary("R2"); entered();
    // R8: NMI beats INTR
    @(negedge clk); nmiReq = 1; intrReq = 1; intrEn = 1; boundary("R8"); entered();
    // R8: disabled INTR falls through to fetch page fault
    @(negedge clk); intrReq = 1; fetchPageFault = 1; boundary("R8"); entered();
    // R2: fetch segmentation codes
    @(negedge clk); fetchSegFault = 1; fetchSegGp = 1; decIllegal = 1; boundary("R2"); entered();
    @(negedge clk); fetchSegFault = 1; fetchPageFault = 1; boundary("R2"); entered();
    // R3: decode order and mode qualification
    @(negedge clk); decProtOnly = 1; boundary("R3");
    @(negedge clk); decProtOnly = 1; realOrV86 = 1; decTooLong = 1; boundary("R3"); entered();
    @(negedge clk); decPrivViol = 1; boundary("R3"); entered();
    // R4: WAIT needs TS and MP; ESCAPE needs EM or TS
    @(negedge clk); opWait = 1; crTs = 1; boundary("R4");
    @(negedge clk); opWait = 1; crTs = 1; crMp = 1; boundary("R4"); entered();
    @(negedge clk); opEsc = 1; crEm = 1; boundary("R4"); entered();
    // R5: vector 7 wins over the error input, else 16
    @(negedge clk); opEsc = 1; crTs = 1; cpErr = 1; boundary("R5"); entered();
    @(negedge clk); opWait = 1; cpErr = 1; boundary("R5"); entered();
    // R6: reference order and seg before page
    @(negedge clk); memSegFault = 2'b10; memSegCode = 4'b0100; memPageFault = 2'b01; boundary("R6"); entered();
    @(negedge clk); memSegFault = 2'b01; memSegCode = 4'b0001; memPageFault = 2'b01; boundary("R6"); entered();
    // R8: external requests masked during a pending entry
    @(negedge clk); fetchSegFault = 1; boundary("R9");
    @(negedge clk); nmiReq = 1; boundary("R8");
    entered();
    @(negedge clk); nmiReq = 1; boundary("R8"); entered();
    // R9: segment entry + other fault -> 8, then R11 shutdown
    @(negedge clk); fetchSegFault = 1; boundary("R9");
    @(negedge clk); decIllegal = 1; boundary("R9");
    @(negedge clk); decIllegal = 1; boundary("R11");
    @(negedge clk); dbgTrap = 1; boundary("R11");
    entered();
    chk(shutdown == 1, "R11", shutdown, 1);
    doReset();
    // R9: segment entry + page fault -> 14
    @(negedge clk); memSegFault = 2'b01; memSegCode = 4'b0010; boundary("R9");
    @(negedge clk); fetchPageFault = 1; boundary("R9");
    // R10: pf entry + pf -> 14 again, then shutdown
    @(negedge clk); memPageFault = 2'b10; boundary("R10");
    @(negedge clk); fetchPageFault = 1; boundary("R11");
    doReset();
    @(negedge clk); fetchPageFault = 1; boundary("R10");
    @(negedge clk); decTooLong = 1; boundary("R10");
    entered();
    // R12: after completion a segment fault is fresh, not a double fault
    @(negedge clk); fetchSegFault = 1; boundary("R12"); entered();

    // R7: random mixes checked against the model
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      dbgTrap = ($urandom % 16) == 0; bkptFault = ($urandom % 16) == 0;
      nmiReq = ($urandom % 12) == 0; intrReq = ($urandom % 8) == 0; intrEn = $urandom % 2;
      intrVec = 8'($urandom % 256);
      fetchSegFault = ($urandom % 12) == 0; fetchSegGp = $urandom % 2;
      fetchPageFault = ($urandom % 10) == 0; decIllegal = ($urandom % 12) == 0;
      decProtOnly = ($urandom % 8) == 0; realOrV86 = $urandom % 2;
      decTooLong = ($urandom % 14) == 0; decPrivViol = ($urandom % 14) == 0;
      opWait = ($urandom % 6) == 0; opEsc = ($urandom % 6) == 0;
      crTs = $urandom % 2; crMp = $urandom % 2; crEm = $urandom % 2; cpErr = $urandom % 2;
      memSegFault = 2'($urandom % 4) & 2'($urandom % 4); memSegCode = 4'($urandom % 16);
      memPageFault = 2'($urandom % 4) & 2'($urandom % 4);
      boundary("R7");
      if (($urandom % 3) == 0) entered();
      if (mState == 6 && ($urandom % 4) == 0) doReset();
    end
    finishRun();
  end
endmodule